// File: doc/BRIEF.md
# Key Entry Buffer with Threshold Interrupt

This block sits behind a keyboard matrix scanner. Each time the scanner finishes a pass it presents a snapshot: a count of pressed keys and, for each, a 7-bit code holding a 4-bit row and a 3-bit column. The block turns each snapshot into eight entry bytes and queues the snapshots in a small buffer. Software reads them through a 32-bit register port: two entry words give the eight bytes of the oldest snapshot, and reading both in order removes it.

An interrupt register reports how many snapshots are pending, a sticky overflow flag and a sticky threshold flag. The threshold flag is set once the pending count reaches a programmed level, and the interrupt output follows it when the enable is on. Software drains the buffer by reading entry-word pairs until the count reads zero. When the buffer is full, a new snapshot replaces the oldest. Register reads are combinational in the same cycle as the select. Writes and the removal of a snapshot take effect at the clock edge that ends the access.

Top module: `keyscan_entry_buf`

## Requirements
- R1: Each entry byte carries a valid flag in bit 7, the row in bits 6:3 and the column in bits 2:0. Entry slot i of the head snapshot sits in byte i mod 4 (slot 0 in bits 7:0) of the word at offset 0x30 for slots 0-3, or of the word at offset 0x34 for slots 4-7.
- R2: Slots at or beyond the snapshot's key count read as 0x00, and a key count above 8 fills all eight slots. With the buffer empty, both entry words read zero.
- R3: Bits 7:4 of the interrupt register (offset 0x4) give the number of pending snapshots. The number grows by one for each snapshot accepted while the buffer is not full, and is zero when the buffer is empty.
- R4: A read of 0x34 that directly follows a read of 0x30 (no other read of 0x34 in between) removes the head snapshot. A read of 0x34 without that earlier read removes nothing, and a removal from an empty buffer changes nothing.
- R5: A snapshot that arrives while DEPTH snapshots are pending drops the oldest one. The count stays at DEPTH and bit 0 of the interrupt register (overflow flag) is set.
- R6: Bit 2 of the interrupt register (threshold flag) is set in the cycle after the pending count is at or above a nonzero threshold. The flag stays set until it is cleared by writing 1 to bit 2. A clear while the condition still holds leaves it set. Writing 1 to bit 0 clears the overflow flag.
- R7: The interrupt output is high exactly while the threshold flag is set and the threshold-interrupt enable (control bit 3) is 1.
- R8: While the block enable (control bit 0) is 0, snapshots from the scanner are ignored.
- R9: The control register (offset 0x0) holds the threshold in bits 17:14, a 10-bit debounce value in bits 13:4, the interrupt enable in bit 3 and the block enable in bit 0. All other bits read zero.
- R10: After reset the control register, both flags and the count are zero, and the interrupt output is low.
- R11: When a snapshot arrives in the same cycle that a removal occurs, the pending count is unchanged and the next-oldest snapshot becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_push | input | 1 | Scanner presents a snapshot this cycle |
| snap_num | input | 4 | Number of pressed keys in the snapshot |
| snap_codes | input | 56 | Key code i in bits 7i+6:7i, row in the upper 4 bits, column in the lower 3 |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is selected |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the ordering of the drain protocol. A lone read of the upper entry word must leave the count alone, and a design that removed on either read would lose snapshots. It fills the buffer past capacity and checks that the surviving head is the second-oldest snapshot; a design that dropped the newest instead would return the wrong bytes. It clears the threshold flag while the count still meets the threshold, where a design that let the clear win would drop an interrupt that is still owed. It also issues a push and a removal in the same cycle, where a design that gave one priority over the other would move the count by one.

// File: rtl/keyscan_buf_pkg.sv
package keyscan_buf_pkg;

  localparam int SLOTS          = 8;
  localparam int ENTRY_W        = 8;
  localparam int CODE_W         = 7;
  localparam int ROW_W          = 4;
  localparam int COL_W          = 3;
  localparam int WORD_W         = 32;
  localparam int SLOTS_PER_WORD = WORD_W / ENTRY_W;
  localparam int SNAP_W         = SLOTS * ENTRY_W;
  localparam int CODES_W        = SLOTS * CODE_W;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_LO   = 8'h30;
  localparam logic [7:0] OFS_HI   = 8'h34;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_IEN_BIT = 3;
  localparam int CTL_DEB_LSB = 4;
  localparam int DEB_W       = 10;
  localparam int CTL_THR_LSB = 14;
  localparam int THR_W       = 4;

  localparam int STS_OVF_BIT = 0;
  localparam int STS_THR_BIT = 2;
  localparam int CNT_LSB     = 4;
  localparam int CNT_FIELD_W = 4;

  typedef logic [SNAP_W-1:0] snap_t;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic [DEB_W-1:0] deb;
    logic             ien;
    logic             en;
  } ctl_t;

endpackage

// File: rtl/keyscan_buf_pack.sv
module keyscan_buf_pack
  import keyscan_buf_pkg::*;
#(
  parameter int NUM_W = 4
) (
  input  logic [NUM_W-1:0]   num,
  input  logic [CODES_W-1:0] codes,
  output snap_t              snap
);

  localparam int NUM_EXT_W = 32;

  logic [NUM_EXT_W-1:0] num_ext;

  assign num_ext = NUM_EXT_W'(num);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic slot_used;
    assign slot_used = (num_ext > NUM_EXT_W'(g));
    always_comb begin
      if (slot_used) begin
        snap[g*ENTRY_W +: ENTRY_W] = {1'b1, codes[g*CODE_W +: CODE_W]};
      end else begin
        snap[g*ENTRY_W +: ENTRY_W] = '0;
      end
    end
  end

endmodule

// File: rtl/keyscan_buf_fifo.sv
module keyscan_buf_fifo
  import keyscan_buf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  snap_t            din,
  output snap_t            head,
  output logic [CNT_W-1:0] occ,
  output logic             empty,
  output logic             full,
  output logic             drop
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  snap_t            mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             do_pop;
  logic             adv_rd;
  logic             state_en;

  assign empty  = (occ_q == '0);
  assign full   = (occ_q == FULL_CNT);
  assign do_pop = pop & ~empty;
  assign adv_rd = do_pop | (push & full);
  assign drop   = push & full & ~do_pop;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    occ_d    = occ_q;
    if (push) begin
      wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
    end
    if (adv_rd) begin
      rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
    end
    if (push && !full && !do_pop) begin
      occ_d = occ_q + 1'b1;
    end else if (do_pop && !push) begin
      occ_d = occ_q - 1'b1;
    end
  end

  assign state_en = push | do_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else if (state_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      occ_q    <= occ_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_store
    logic we;
    assign we = push & (wr_ptr_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (we) begin
        mem[g] <= din;
      end
    end
  end

  assign head = mem[rd_ptr_q];
  assign occ  = occ_q;

endmodule

// File: rtl/keyscan_buf_regs.sv
module keyscan_buf_regs
  import keyscan_buf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_sel,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  input  logic [CNT_FIELD_W-1:0] cnt,
  input  logic                   empty,
  input  snap_t                  head,
  input  logic                   drop,
  output ctl_t                   ctl,
  output logic                   pop_req,
  output logic                   sts_thr,
  output logic                   sts_ovf,
  output logic                   irq
);

  ctl_t ctl_q, ctl_d;
  logic ctl_we;
  logic thr_q, thr_d;
  logic ovf_q, ovf_d;
  logic arm_q, arm_d;
  logic sts_en, arm_en;
  logic wr_ctrl, wr_stat, rd_lo, rd_hi;
  logic thr_hit;
  logic clr_thr, clr_ovf;
  logic unused_wbits;

  assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == OFS_CTRL);
  assign wr_stat = bus_sel &  bus_wr & (bus_addr == OFS_STAT);
  assign rd_lo   = bus_sel & ~bus_wr & (bus_addr == OFS_LO);
  assign rd_hi   = bus_sel & ~bus_wr & (bus_addr == OFS_HI);

  assign unused_wbits = ^{bus_wdata[WORD_W-1:CTL_THR_LSB+THR_W], bus_wdata[1]};

  // control register
  always_comb begin
    ctl_d.thr = bus_wdata[CTL_THR_LSB +: THR_W];
    ctl_d.deb = bus_wdata[CTL_DEB_LSB +: DEB_W];
    ctl_d.ien = bus_wdata[CTL_IEN_BIT];
    ctl_d.en  = bus_wdata[CTL_EN_BIT];
  end
  assign ctl_we = wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  // status flags: setting wins over a write-one clear
  assign thr_hit = (ctl_q.thr != '0) && (cnt >= ctl_q.thr);
  assign clr_thr = wr_stat & bus_wdata[STS_THR_BIT];
  assign clr_ovf = wr_stat & bus_wdata[STS_OVF_BIT];

  always_comb begin
    thr_d = thr_hit | (thr_q & ~clr_thr);
    ovf_d = drop    | (ovf_q & ~clr_ovf);
  end
  assign sts_en = thr_hit | drop | wr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      ovf_q <= 1'b0;
    end else if (sts_en) begin
      thr_q <= thr_d;
      ovf_q <= ovf_d;
    end
  end

  // drain sequencing: low word read arms, high word read consumes
  always_comb begin
    arm_d = arm_q;
    if (rd_lo) begin
      arm_d = 1'b1;
    end else if (rd_hi) begin
      arm_d = 1'b0;
    end
  end
  assign arm_en = rd_lo | rd_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (arm_en) begin
      arm_q <= arm_d;
    end
  end

  assign pop_req = rd_hi & arm_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        OFS_CTRL: bus_rdata = {{(WORD_W-CTL_THR_LSB-THR_W){1'b0}}, ctl_q.thr, ctl_q.deb,
                               ctl_q.ien, 2'b00, ctl_q.en};
        OFS_STAT: bus_rdata = {{(WORD_W-CNT_LSB-CNT_FIELD_W){1'b0}}, cnt, 1'b0, thr_q, 1'b0, ovf_q};
        OFS_LO:   bus_rdata = empty ? '0 : head[0 +: WORD_W];
        OFS_HI:   bus_rdata = empty ? '0 : head[WORD_W +: WORD_W];
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign ctl     = ctl_q;
  assign sts_thr = thr_q;
  assign sts_ovf = ovf_q;
  assign irq     = thr_q & ctl_q.ien;

endmodule

// File: rtl/keyscan_entry_buf.sv
module keyscan_entry_buf
  import keyscan_buf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               snap_push,
  input  logic [3:0]         snap_num,
  input  logic [CODES_W-1:0] snap_codes,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               irq
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             rst_meta_q, rst_sync_n;
  snap_t            packed_snap;
  snap_t            head;
  logic [CNT_W-1:0] occ;
  logic             empty, full, drop;
  logic             push_acc;
  logic             pop_req;
  ctl_t             ctl;
  logic             ctl_en, ctl_ien;
  logic [THR_W-1:0] ctl_thr;
  logic             sts_thr, sts_ovf;
  logic [CNT_FIELD_W-1:0] cnt_field;
  logic             unused_sts;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  keyscan_buf_pack #(.NUM_W(4)) pack_i (
    .num   (snap_num),
    .codes (snap_codes),
    .snap  (packed_snap)
  );

  assign push_acc = snap_push & ctl_en;

  keyscan_buf_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .push  (push_acc),
    .pop   (pop_req),
    .din   (packed_snap),
    .head  (head),
    .occ   (occ),
    .empty (empty),
    .full  (full),
    .drop  (drop)
  );

  assign cnt_field = CNT_FIELD_W'(occ);

  keyscan_buf_regs regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cnt       (cnt_field),
    .empty     (empty),
    .head      (head),
    .drop      (drop),
    .ctl       (ctl),
    .pop_req   (pop_req),
    .sts_thr   (sts_thr),
    .sts_ovf   (sts_ovf),
    .irq       (irq)
  );

  assign ctl_en     = ctl.en;
  assign ctl_ien    = ctl.ien;
  assign ctl_thr    = ctl.thr;
  assign unused_sts = ^{sts_ovf, full, ctl.deb};

endmodule

// File: rtl/keyscan_entry_buf_chk.sv
module keyscan_entry_buf_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             push_acc,
  input logic             pop_req,
  input logic [CNT_W-1:0] occ,
  input logic             ctl_en,
  input logic             ctl_ien,
  input logic [3:0]       ctl_thr,
  input logic             sts_thr
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  AST_OCC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_CNT);  // R3

  AST_FULL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_CNT && push_acc && !pop_req) |=> (occ == FULL_CNT));  // R5

  AST_POP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_acc && occ != '0) |=> (occ == $past(occ) - 1'b1));  // R4

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !pop_req) |=> (occ == $past(occ)));  // R8

  AST_THR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_thr != 4'd0 && 4'(occ) >= ctl_thr) |=> sts_thr);  // R6

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_thr || !ctl_ien) |-> !irq);  // R7

endmodule

bind keyscan_entry_buf keyscan_entry_buf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .irq      (irq),
  .push_acc (push_acc),
  .pop_req  (pop_req),
  .occ      (occ),
  .ctl_en   (ctl_en),
  .ctl_ien  (ctl_ien),
  .ctl_thr  (ctl_thr),
  .sts_thr  (sts_thr)
);

// File: tb/keyscan_entry_buf_tb_top.sv
`timescale 1ns/1ps
module keyscan_entry_buf_tb_top;

  localparam int DEPTH = 4;

  logic        clk;
  logic        rst_n;
  logic        snap_push;
  logic [3:0]  snap_num;
  logic [55:0] snap_codes;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_vec;
  int n_bad;
  bit done;

  keyscan_entry_buf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .snap_push(snap_push), .snap_num(snap_num),
    .snap_codes(snap_codes), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector table: {key count, code seed}
  localparam logic [11:0] VEC [6] = '{
    {4'd1,  8'h15}, {4'd8,  8'h3C}, {4'd0,  8'h77},
    {4'd5,  8'h02}, {4'd4,  8'hE9}, {4'd12, 8'h51}
  };

  function automatic logic [55:0] gen_codes(input logic [7:0] seed);
    logic [55:0] c;
    for (int i = 0; i < 8; i++) c[i*7 +: 7] = 7'(int'(seed) * 11 + i * 19 + 3);
    return c;
  endfunction

  // R1 / R2: expected 64-bit image of a snapshot
  function automatic logic [63:0] exp_snap(input logic [3:0] num, input logic [7:0] seed);
    logic [55:0] c;
    logic [63:0] r;
    c = gen_codes(seed);
    for (int i = 0; i < 8; i++) r[i*8 +: 8] = (i < int'(num)) ? {1'b1, c[i*7 +: 7]} : 8'h00;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  task automatic push(input logic [3:0] num, input logic [55:0] codes);
    @(negedge clk);
    snap_push = 1'b1; snap_num = num; snap_codes = codes;
    @(posedge clk); #1;
    snap_push = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pop_check(input string req, input logic [63:0] exp);
    logic [31:0] lo, hi;
    bus_read(8'h30, lo);
    bus_read(8'h34, hi);
    check(req, lo, exp[31:0]);
    check(req, hi, exp[63:32]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  num;
    logic [7:0]  seed;
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; snap_push = 1'b0; snap_num = '0; snap_codes = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R10 reset state, R2 empty reads
    bus_read(8'h00, rd); check("R10 ctrl", rd, 32'h0);
    bus_read(8'h04, rd); check("R10 stat", rd, 32'h0);
    bus_read(8'h30, rd); check("R2 empty lo", rd, 32'h0);
    bus_read(8'h34, rd); check("R2 empty hi", rd, 32'h0);
    check("R10 irq", 32'(irq), 32'h0);

    // R9 control fields, other bits dropped
    bus_write(8'h00, 32'h8000_0000 | (32'd3 << 14) | (32'h155 << 4) | 32'h8 | 32'h4 | 32'h1);
    bus_read(8'h00, rd); check("R9 ctrl readback", rd, (32'd3 << 14) | (32'h155 << 4) | 32'h9);
    bus_write(8'h00, 32'h1);   // enable, no threshold

    // R1 direct field placement: row 9 col 6
    push(4'd1, 56'(7'h4E));
    pop_check("R1 row/col", {32'h0, 32'h0000_00CE});

    // vector table walk (R1 R2 R3 R4)
    for (int v = 0; v < 6; v++) begin
      num  = VEC[v][11:8];
      seed = VEC[v][7:0];
      push(num, gen_codes(seed));
      bus_read(8'h04, rd); check("R3 count one", {24'h0, rd[7:4], 4'h0}, 32'h10);
      pop_check("R1 R2 snapshot", exp_snap(num, seed));
      bus_read(8'h04, rd); check("R4 drained", {24'h0, rd[7:4], 4'h0}, 32'h0);
    end

    // R4 lone high read does not consume
    push(4'd2, gen_codes(8'h90));
    bus_read(8'h34, rd);
    bus_read(8'h04, rd); check("R4 lone hi keeps", rd, 32'h10);
    pop_check("R4 pair consumes", exp_snap(4'd2, 8'h90));

    // R8 disabled block ignores snapshots
    bus_write(8'h00, 32'h0);
    push(4'd3, gen_codes(8'h11));
    idle(1);
    bus_read(8'h04, rd); check("R8 ignored", rd, 32'h0);

    // R6 / R7 threshold flag and interrupt
    bus_write(8'h00, (32'd3 << 14) | 32'h1);
    push(4'd8, gen_codes(8'hA1));
    push(4'd8, gen_codes(8'hA2));
    push(4'd8, gen_codes(8'hA3));
    idle(1);
    bus_read(8'h04, rd); check("R6 flag set", rd, 32'h34);
    check("R7 irq gated off", 32'(irq), 32'h0);
    bus_write(8'h00, (32'd3 << 14) | 32'h9);
    @(negedge clk); check("R7 irq on", 32'(irq), 32'h1);
    bus_write(8'h04, 32'h4);
    bus_read(8'h04, rd); check("R6 clear loses to set", rd, 32'h34);
    pop_check("R6 head", exp_snap(4'd8, 8'hA1));
    bus_read(8'h04, rd); check("R6 sticky", rd, 32'h24);
    bus_write(8'h04, 32'h4);
    bus_read(8'h04, rd); check("R6 cleared", rd, 32'h20);
    @(negedge clk); check("R7 irq off", 32'(irq), 32'h0);

    // R5 overflow replaces oldest
    push(4'd8, gen_codes(8'hA4));
    push(4'd8, gen_codes(8'hA5));
    push(4'd8, gen_codes(8'hA6));
    bus_read(8'h04, rd); check("R5 saturated + flag", rd, 32'h45);
    pop_check("R5 oldest dropped", exp_snap(4'd8, 8'hA3));
    bus_write(8'h04, 32'h7);
    bus_read(8'h04, rd); check("R6 ovf cleared", rd, 32'h34);

    // R11 push and removal in one cycle
    bus_read(8'h30, rd);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h34;
    snap_push = 1'b1; snap_num = 4'd8; snap_codes = gen_codes(8'hA7);
    @(posedge clk); #1;
    bus_sel = 1'b0; snap_push = 1'b0;
    bus_read(8'h04, rd); check("R11 count kept", {24'h0, rd[7:4], 4'h0}, 32'h30);
    pop_check("R11 next head", exp_snap(4'd8, 8'hA5));
    pop_check("R11 order", exp_snap(4'd8, 8'hA6));
    pop_check("R11 newest", exp_snap(4'd8, 8'hA7));

    // R4 removal from empty buffer
    pop_check("R4 empty pop", 64'h0);
    bus_read(8'h04, rd); check("R4 empty count", {24'h0, rd[7:4], 4'h0}, 32'h0);

    // R10 reset mid-operation
    push(4'd2, gen_codes(8'h33));
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(4);
    bus_read(8'h00, rd); check("R10 ctrl after reset", rd, 32'h0);
    bus_read(8'h04, rd); check("R10 stat after reset", rd, 32'h0);
    check("R10 irq after reset", 32'(irq), 32'h0);

    finish_run();
  end

endmodule